// File: doc/BRIEF.md
# 128-bit Compare-and-Exchange Unit

This block performs an atomic 16-byte compare-and-swap against a memory port that moves 64-bit beats. On a start pulse it captures an address, a 128-bit expected value (given as two 64-bit halves), a 128-bit replacement value (also two halves) and a flags word. If the address is not 16-byte aligned, the block reports a protection fault and makes no memory access. Otherwise it reads the two halves of the target location. It compares the 128-bit result with the expected value and always writes two words back. On a match it writes the replacement value. On a mismatch it writes back the value it just read.

The outcome is reported in three ways: a zero bit inside the returned flags word, a register-update strobe, and the returned halves. On a mismatch the returned halves are the words that were read, so the caller can reload its expected-value registers. A lock output covers the whole read-modify-write sequence so that a surrounding fabric can keep other masters away from the location. The memory port uses a request/ready handshake. A beat completes in any cycle where both the request and ready are high, and read data is taken in that cycle.

Top module: `cas128_unit`

## Requirements
- R1: A start whose address has any of bits [3:0] set causes done with fault=1 on the second clock edge after start. No memory request is made, regUpdate is 0 and flagsOut equals the captured flags unchanged.
- R2: An aligned operation performs exactly four beats in this order: read at addr, read at addr+8, write at addr, write at addr+8. The word at addr is the low 64 bits.
- R3: When {read hi, read lo} equals {cmpHi, cmpLo}, the writes store newLo at addr and newHi at addr+8. flagsOut equals flagsIn with bit ZF_BIT (default 6) set.
- R4: On a mismatch, the words that were read are written back unchanged. regUpdate=1, resLo/resHi carry the read low/high words, and flagsOut equals flagsIn with bit ZF_BIT cleared.
- R5: On a match or a fault, regUpdate=0 and resLo/resHi return cmpLo/cmpHi unchanged.
- R6: lock is high in every cycle where memReq is high. It rises with the first read request and is low again by the cycle done is high.
- R7: done is high for exactly one cycle per accepted start, and fault, regUpdate, resLo, resHi and flagsOut are valid in that cycle.
- R8: A start while busy is high is ignored: the running operation completes with its originally captured operands.
- R9: While memReq is high and memReady is low, memReq, memWe and memAddr hold their values into the next cycle.
- R10: After reset the block is idle: busy, done, memReq and lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| addr | input | ADDR_W | Byte address of the 16-byte target |
| cmpLo | input | WORD_W | Expected value, low half |
| cmpHi | input | WORD_W | Expected value, high half |
| newLo | input | WORD_W | Replacement value, low half |
| newHi | input | WORD_W | Replacement value, high half |
| flagsIn | input | FLAG_W | Flags word to be updated |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Alignment fault, valid with done |
| regUpdate | output | 1 | Caller should reload its expected-value halves |
| resLo | output | WORD_W | Returned low half |
| resHi | output | WORD_W | Returned high half |
| flagsOut | output | FLAG_W | Updated flags, valid with done |
| lock | output | 1 | Atomic sequence in progress on the memory port |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | ADDR_W | Beat byte address |
| memWdata | output | WORD_W | Write data |
| memReady | input | 1 | Memory accepts the beat this cycle |
| memRdata | input | WORD_W | Read data, valid when a read beat completes |

## Verification
A wrong sequencer state shows up on the memory port at the next beat, as an extra, missing or misordered access or one to the wrong half address. It is visible within one handshake, and the per-operation beat log catches it. A corrupted captured operand or read-back register only shows when done fires. It appears as a wrong written word in memory, a wrong zero bit or wrong returned halves, all of which are compared in that cycle. Lock or stall-hold errors are visible in the very cycle they occur, because the bench checks the port every cycle under a ready pattern that stalls.

// File: rtl/cas128_pkg.sv
package cas128_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RDLO = 3'd1,
    S_RDHI = 3'd2,
    S_WRLO = 3'd3,
    S_WRHI = 3'd4,
    S_DONE = 3'd5
  } casState_t;

  typedef struct packed {
    logic capture;   // latch operands from the ports
    logic latchLo;   // latch read data as low half
    logic latchHi;   // latch read data as high half
    logic selHi;     // current beat targets the +8 word
    logic present;   // result outputs are valid
  } casStrobe_t;

endpackage

// File: rtl/cas128_eq.sv
module cas128_eq #(
  parameter int WORD_W = 64,
  parameter int LANES  = 2
) (
  input  logic [LANES*WORD_W-1:0] aVec,
  input  logic [LANES*WORD_W-1:0] bVec,
  output logic                    equal
);
  logic [LANES-1:0] laneEq;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEq[g] = (aVec[g*WORD_W +: WORD_W] == bVec[g*WORD_W +: WORD_W]);
  end

  assign equal = &laneEq;
endmodule

// File: rtl/cas128_ctrl.sv
module cas128_ctrl
  import cas128_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       misaligned,
  input  logic       memReady,
  output casStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       lock,
  output logic       busy,
  output logic       done
);
  casState_t state, stateNext;
  logic lockQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (start) stateNext = misaligned ? S_DONE : S_RDLO;
      S_RDLO: if (memReady) stateNext = S_RDHI;
      S_RDHI: if (memReady) stateNext = S_WRLO;
      S_WRLO: if (memReady) stateNext = S_WRHI;
      S_WRHI: if (memReady) stateNext = S_DONE;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      lockQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start && !misaligned) begin
        lockQ <= 1'b1;
      end else if (state == S_WRHI && memReady) begin
        lockQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == S_IDLE) && start;
    strobe.latchLo = (state == S_RDLO) && memReady;
    strobe.latchHi = (state == S_RDHI) && memReady;
    strobe.selHi   = (state == S_RDHI) || (state == S_WRHI);
    strobe.present = (state == S_DONE);
  end

  assign memReq = (state == S_RDLO) || (state == S_RDHI) ||
                  (state == S_WRLO) || (state == S_WRHI);
  assign memWe  = (state == S_WRLO) || (state == S_WRHI);
  assign lock   = lockQ;
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
endmodule

// File: rtl/cas128_dpath.sv
module cas128_dpath
  import cas128_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int WORD_W     = 64,
  parameter int FLAG_W     = 32,
  parameter int ZF_BIT     = 6,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  casStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] cmpLo,
  input  logic [WORD_W-1:0] cmpHi,
  input  logic [WORD_W-1:0] newLo,
  input  logic [WORD_W-1:0] newHi,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic              misaligned,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              fault,
  output logic              regUpdate,
  output logic [WORD_W-1:0] resLo,
  output logic [WORD_W-1:0] resHi,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int STEP = WORD_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] cmpLoQ, cmpHiQ, newLoQ, newHiQ, oldLoQ, oldHiQ;
  logic [FLAG_W-1:0] flagsQ;
  logic              faultQ;
  logic              match;
  logic [FLAG_W-1:0] flagsZf;

  assign misaligned = |addr[ALIGN_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      cmpLoQ <= '0;
      cmpHiQ <= '0;
      newLoQ <= '0;
      newHiQ <= '0;
      flagsQ <= '0;
      faultQ <= 1'b0;
      oldLoQ <= '0;
      oldHiQ <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= addr;
        cmpLoQ <= cmpLo;
        cmpHiQ <= cmpHi;
        newLoQ <= newLo;
        newHiQ <= newHi;
        flagsQ <= flagsIn;
        faultQ <= misaligned;
      end
      if (strobe.latchLo) oldLoQ <= memRdata;
      if (strobe.latchHi) oldHiQ <= memRdata;
    end
  end

  cas128_eq #(.WORD_W(WORD_W), .LANES(2)) u_eq (
    .aVec ({oldHiQ, oldLoQ}),
    .bVec ({cmpHiQ, cmpLoQ}),
    .equal(match)
  );

  assign memAddr  = addrQ + (strobe.selHi ? ADDR_W'(STEP) : '0);
  assign memWdata = match ? (strobe.selHi ? newHiQ : newLoQ)
                          : (strobe.selHi ? oldHiQ : oldLoQ);

  always_comb begin
    flagsZf         = flagsQ;
    flagsZf[ZF_BIT] = match;
  end

  assign fault     = strobe.present && faultQ;
  assign regUpdate = strobe.present && !faultQ && !match;
  assign resLo     = regUpdate ? oldLoQ : cmpLoQ;
  assign resHi     = regUpdate ? oldHiQ : cmpHiQ;
  assign flagsOut  = !strobe.present ? '0 : (faultQ ? flagsQ : flagsZf);
endmodule

// File: rtl/cas128_unit.sv
module cas128_unit
  import cas128_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int WORD_W     = 64,
  parameter int FLAG_W     = 32,
  parameter int ZF_BIT     = 6,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] cmpLo,
  input  logic [WORD_W-1:0] cmpHi,
  input  logic [WORD_W-1:0] newLo,
  input  logic [WORD_W-1:0] newHi,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              regUpdate,
  output logic [WORD_W-1:0] resLo,
  output logic [WORD_W-1:0] resHi,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              lock,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata
);
  casStrobe_t strobe;
  logic       misaligned;

  cas128_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .misaligned(misaligned),
    .memReady  (memReady),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .lock      (lock),
    .busy      (busy),
    .done      (done)
  );

  cas128_dpath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FLAG_W(FLAG_W),
    .ZF_BIT(ZF_BIT), .ALIGN_BITS(ALIGN_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (addr),
    .cmpLo     (cmpLo),
    .cmpHi     (cmpHi),
    .newLo     (newLo),
    .newHi     (newHi),
    .flagsIn   (flagsIn),
    .memRdata  (memRdata),
    .misaligned(misaligned),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .fault     (fault),
    .regUpdate (regUpdate),
    .resLo     (resLo),
    .resHi     (resHi),
    .flagsOut  (flagsOut)
  );
endmodule

// File: rtl/cas128_chk.sv
module cas128_chk #(
  parameter int ADDR_W     = 48,
  parameter int WORD_W     = 64,
  parameter int FLAG_W     = 32,
  parameter int ZF_BIT     = 6,
  parameter int ALIGN_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              regUpdate,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              lock,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady
);
  a_r1_fault_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (|addr[ALIGN_BITS-1:0])) |=> (done && fault && !memReq && !regUpdate));

  a_r3_match_sets_zf: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && !regUpdate) |-> flagsOut[ZF_BIT]);

  a_r4_update_clears_zf: assert property (@(posedge clk) disable iff (!rstN)
    regUpdate |-> (done && !fault && !flagsOut[ZF_BIT]));

  a_r6_req_under_lock: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> lock);

  a_r6_lock_off_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !lock);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !lock && !done));
endmodule

bind cas128_unit cas128_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FLAG_W(FLAG_W),
  .ZF_BIT(ZF_BIT), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .addr     (addr),
  .busy     (busy),
  .done     (done),
  .fault    (fault),
  .regUpdate(regUpdate),
  .flagsOut (flagsOut),
  .lock     (lock),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memReady (memReady)
);

// File: tb/cas128_unit_tb.sv
module cas128_unit_tb;
  localparam int ADDR_W = 48;
  localparam int WORD_W = 64;
  localparam int FLAG_W = 32;
  localparam int ZF_BIT = 6;

  typedef struct packed {
    logic              fault;
    logic              upd;
    logic [WORD_W-1:0] resLo;
    logic [WORD_W-1:0] resHi;
    logic [FLAG_W-1:0] flags;
    logic [ADDR_W-1:0] base;
    logic [WORD_W-1:0] memLo;
    logic [WORD_W-1:0] memHi;
    int                nAcc;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] cmpLo = '0, cmpHi = '0, newLo = '0, newHi = '0;
  logic [FLAG_W-1:0] flagsIn = '0;
  logic busy, done, fault, regUpdate, lock, memReq, memWe;
  logic [WORD_W-1:0] resLo, resHi, memWdata, memRdata;
  logic [FLAG_W-1:0] flagsOut;
  logic [ADDR_W-1:0] memAddr;
  logic memReady;

  logic [WORD_W-1:0] mem [0:15];
  logic stallOn = 1'b0;
  logic [1:0] rdyCnt = '0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  expItem_t expQ[$];

  logic              logWe   [0:7];
  logic [ADDR_W-1:0] logAddr [0:7];
  int                logN = 0;

  always #10 clk = ~clk;

  cas128_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr),
    .cmpLo(cmpLo), .cmpHi(cmpHi), .newLo(newLo), .newHi(newHi), .flagsIn(flagsIn),
    .busy(busy), .done(done), .fault(fault), .regUpdate(regUpdate),
    .resLo(resLo), .resHi(resHi), .flagsOut(flagsOut), .lock(lock),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  assign memReady = stallOn ? (rdyCnt == 2'd0) : 1'b1;
  assign memRdata = mem[memAddr[6:3]];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model and beat log
  always @(posedge clk) begin
    rdyCnt <= rdyCnt + 2'd1;
    cycles <= cycles + 1;
    if (done) begin
      logN <= 0;
    end else if (memReq && memReady) begin
      if (logN < 8) begin
        logWe[logN]   <= memWe;
        logAddr[logN] <= memAddr;
      end
      logN <= logN + 1;
      if (memWe) mem[memAddr[6:3]] <= memWdata;
    end
  end

  // per-cycle port monitor: lock, stall hold, done pulse
  logic prevStall = 1'b0;
  logic prevDone = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic prevWe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) chk(lock, "R6 lock with request", {127'd0, lock}, 128'd1);
      if (prevStall)
        chk(memReq && memAddr == prevAddr && memWe == prevWe, "R9 hold on stall",
            {79'd0, memReq, memAddr}, {79'd0, 1'b1, prevAddr});
      if (prevDone) chk(!done, "R7 single-cycle done", {127'd0, done}, 128'd0);
      prevStall = memReq && !memReady;
      prevAddr  = memAddr;
      prevWe    = memWe;
      prevDone  = done;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 128'd1, 128'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(fault == e.fault, "R1 fault", {127'd0, fault}, {127'd0, e.fault});
        chk(regUpdate == e.upd, "R4/R5 regUpdate", {127'd0, regUpdate}, {127'd0, e.upd});
        chk(flagsOut == e.flags, "R3/R4 flagsOut", {96'd0, flagsOut}, {96'd0, e.flags});
        chk({resHi, resLo} == {e.resHi, e.resLo}, "R4/R5 returned halves",
            {resHi, resLo}, {e.resHi, e.resLo});
        chk(!lock, "R6 lock low at done", {127'd0, lock}, 128'd0);
        chk(logN == e.nAcc, "R2 beat count", 128'(logN), 128'(e.nAcc));
        if (!e.fault && logN == 4) begin
          chk(logWe[0] == 0 && logAddr[0] == e.base, "R2 beat0 read lo",
              {79'd0, logWe[0], logAddr[0]}, {80'd0, e.base});
          chk(logWe[1] == 0 && logAddr[1] == e.base + 8, "R2 beat1 read hi",
              {79'd0, logWe[1], logAddr[1]}, {80'd0, e.base + 48'd8});
          chk(logWe[2] == 1 && logAddr[2] == e.base, "R2 beat2 write lo",
              {79'd0, logWe[2], logAddr[2]}, {79'd0, 1'b1, e.base});
          chk(logWe[3] == 1 && logAddr[3] == e.base + 8, "R2 beat3 write hi",
              {79'd0, logWe[3], logAddr[3]}, {79'd0, 1'b1, e.base + 48'd8});
        end
        if (!e.fault)
          chk({mem[e.base[6:3] + 4'd1], mem[e.base[6:3]]} == {e.memHi, e.memLo},
              "R3/R4 memory after write", {mem[e.base[6:3] + 4'd1], mem[e.base[6:3]]},
              {e.memHi, e.memLo});
      end
    end
  end

  // driver: computes expectation from bench memory, pushes it, runs the op
  task automatic runOp(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] cL,
                       input logic [WORD_W-1:0] cH, input logic [WORD_W-1:0] nL,
                       input logic [WORD_W-1:0] nH, input logic [FLAG_W-1:0] f,
                       input bit doubleStart);
    expItem_t e;
    logic [WORD_W-1:0] oL, oH;
    bit isMatch;
    e = '0;
    e.base  = a;
    e.fault = (a[3:0] != 4'd0);
    e.resLo = cL;
    e.resHi = cH;
    e.flags = f;
    e.nAcc  = 0;
    if (!e.fault) begin
      oL = mem[a[6:3]];
      oH = mem[a[6:3] + 4'd1];
      isMatch = ({oH, oL} == {cH, cL});
      e.nAcc = 4;
      e.flags[ZF_BIT] = isMatch;
      e.upd = !isMatch;
      if (isMatch) begin
        e.memLo = nL; e.memHi = nH;
      end else begin
        e.memLo = oL; e.memHi = oH;
        e.resLo = oL; e.resHi = oH;
      end
    end
    expQ.push_back(e);
    @(negedge clk);
    addr = a; cmpLo = cL; cmpHi = cH; newLo = nL; newHi = nH; flagsIn = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (doubleStart) begin
      @(negedge clk);
      // R8: second start while busy with other operands must be ignored
      chk(busy, "R8 busy at second start", {127'd0, busy}, 128'd1);
      addr = a ^ 48'h10; cmpLo = ~cL; cmpHi = ~cH; newLo = ~nL; newHi = ~nH; flagsIn = ~f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R7 idle after done", {127'd0, busy}, 128'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {32'hC0DE0000 + i, 32'h5A5A0000 ^ (i * 32'h1111)};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy, "R10 busy", {127'd0, busy}, 128'd0);
    chk(!done, "R10 done", {127'd0, done}, 128'd0);
    chk(!memReq, "R10 memReq", {127'd0, memReq}, 128'd0);
    chk(!lock, "R10 lock", {127'd0, lock}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 match, no stall
    runOp(48'h10, mem[2], mem[3], 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 32'h0000_0001, 0);
    // R4 mismatch in high half
    runOp(48'h20, mem[4], ~mem[5], 64'hDEAD, 64'hBEEF, 32'hFFFF_FFFF, 0);
    stallOn = 1'b1;
    // R4 mismatch in low half, with stalls (R9)
    runOp(48'h30, mem[6] ^ 64'h1, mem[7], 64'hAA, 64'hBB, 32'h0000_0040, 0);
    // R3 and R8: match with stall and ignored second start
    runOp(48'h40, mem[8], mem[9], 64'hFEED_F00D, 64'hCAFE_BABE, 32'h1234_5678, 1);
    stallOn = 1'b0;
    // R1 misaligned, bit 3 set and bit 0 set
    runOp(48'h18, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0000_0040, 0);
    runOp(48'h21, 64'h0, 64'h0, 64'h0, 64'h0, 32'hA5A5_A5A5, 0);
    // R4 and R8: mismatch with ignored second start
    runOp(48'h50, ~mem[10], ~mem[11], 64'h1, 64'h2, 32'h0, 1);
    // R3 at top of window, then R4 repeat on the same location with stale compare
    runOp(48'h70, mem[14], mem[15], 64'h7777, 64'h8888, 32'h8000_0000, 0);
    runOp(48'h70, 64'h0, 64'h0, 64'h9, 64'h9, 32'h0, 0);
    // R5: match after previous update path
    runOp(48'h10, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0, 64'h0, 32'h0, 0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R7 all results seen", 128'(expQ.size()), 128'd0);
    finishRun();
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finishRun();
  end
endmodule